// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers eight peripheral request lines onto one active-low interrupt output to a processor. Each line is captured in a sticky pending register and gated by an enable register. Software reaches both registers through a small register port. Bit 3 is a reserved hole that can never request. The remaining bits are two push-buttons (7, 6), serial transmit ready (5), serial receive ready (4), two external logic requests (2, 1) and the timer compare (0).

On top of the plain gate-and-merge, the block nests interrupts in hardware. It holds the priority level now being serviced, and it only asserts the interrupt line for a pending, enabled source whose level is strictly above that level. Source *i* has level *i*+1, and level 0 means idle. When the processor acknowledges, the block picks the highest pending source. It pushes the old level onto a last-in-first-out stack and enters the new level. On end-of-interrupt it pops the stack and resumes the level that was preempted. A read-only vector register reports which source was acknowledged last.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on a source line sets that source's bit in the pending register at offset 0x18. The bit stays set until a write to 0x18 with a 1 in that bit position clears it. A pulse and a clearing write in the same cycle leave the bit set.
- R2: The enable register at offset 0x1C is written by a register write and read back with the written value.
- R3: Bit 3 is reserved. It always reads 0 in both the pending and the enable register, and a pulse on source 3 never drives the interrupt output low.
- R4: `irq_n` is low exactly when some source *i* is pending and enabled and its level *i*+1 is above `svc_level`. Otherwise it is high.
- R5: An acknowledge picks the highest-numbered qualifying source. Its number then reads in bits 2:0 of the vector register at offset 0x20, and `svc_level` becomes that number plus one.
- R6: During service, a pending source at the same or a lower level does not drive `irq_n` low. A strictly higher one does, and acknowledging it saves the old level on the stack.
- R7: An end-of-interrupt restores `svc_level` to the most recently saved level, so nested services unwind in reverse order.
- R8: An end-of-interrupt with an empty stack, or an acknowledge of a qualifying source while the stack is full, sets the sticky `stk_err` output and leaves `svc_level` and the vector unchanged. Only reset clears `stk_err`.
- R9: An acknowledge while `irq_n` is high is ignored: `svc_level` and the vector do not change.
- R10: After reset, pending, enable and vector read 0, `svc_level` is 0, `irq_n` is high and `stk_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | NSRC | Request pulses from the peripherals |
| reg_addr | input | AW | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | NSRC | Register write data |
| reg_rdata | output | NSRC | Register read data, combinational from reg_addr |
| int_ack | input | 1 | Processor acknowledge, one cycle |
| int_eoi | input | 1 | End of interrupt, one cycle; wins over int_ack |
| irq_n | output | 1 | Active-low interrupt request |
| svc_level | output | LW | Level now in service, 0 when idle |
| stk_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
A corrupted level stack shows up on the first end-of-interrupt after the fault, because `svc_level` then resumes a wrong level. It also shows on `irq_n` in the same cycle, since the gating threshold moves with the level. A wrong pending or enable bit shows up immediately on a register read and on `irq_n`. A wrong priority pick shows up in the vector register and `svc_level` one clock after the acknowledge. The directed scenarios nest three levels deep, unwind them, and drive both stack limits. After each step they read back the state at the ports.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int NSRC_DEF   = 8;
    localparam int RSVD_DEF   = 3;
    localparam int DEPTH_DEF  = 8;
    localparam int AW_DEF     = 6;
    localparam logic [7:0] OFS_PEND = 8'h18;
    localparam logic [7:0] OFS_ENAB = 8'h1C;
    localparam logic [7:0] OFS_VECT = 8'h20;
endpackage

// File: rtl/nic_src_regs.sv
module nic_src_regs #(
    parameter int N        = nic_pkg::NSRC_DEF,
    parameter int RSVD_BIT = nic_pkg::RSVD_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_pulse,
    input  logic         pend_we,
    input  logic         enab_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] pend,
    output logic [N-1:0] enab
);
    localparam logic [N-1:0] LIVE = ~(N'(1) << RSVD_BIT);

    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] enab;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // clearing write first, new pulses override it
        r_d.pend = ((r_q.pend & ~(pend_we ? wdata : '0)) | src_pulse) & LIVE;
        if (enab_we) r_d.enab = wdata & LIVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pend = r_q.pend;
    assign enab = r_q.enab;

    for (genvar g = 0; g < N; g++) begin : g_chk
        if (g != RSVD_BIT) begin : g_live
            assert_pulse_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
                src_pulse[g] |=> pend[g]);
        end
    end
endmodule

// File: rtl/nic_prio_pick.sv
module nic_prio_pick #(
    parameter int N  = nic_pkg::NSRC_DEF,
    parameter int LW = $clog2(N + 1),
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  enab,
    input  logic [LW-1:0] cur_lvl,
    output logic          any,
    output logic [IW-1:0] win_idx,
    output logic [LW-1:0] win_lvl
);
    logic [N-1:0] elig;

    for (genvar g = 0; g < N; g++) begin : g_elig
        assign elig[g] = pend[g] && enab[g] && (LW'(g + 1) > cur_lvl);
    end

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i]) win_idx = IW'(i);
        end
    end

    assign any     = |elig;
    assign win_lvl = LW'(win_idx) + LW'(1);
endmodule

// File: rtl/nic_lvl_stack.sv
module nic_lvl_stack #(
    parameter int DEPTH = nic_pkg::DEPTH_DEF,
    parameter int W     = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top_val,
    output logic         empty,
    output logic         full,
    output logic         err
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CW-1:0]           cnt;
        logic                    err;
    } stk_t;

    stk_t s_d, s_q;

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CW'(DEPTH));

    always_comb begin
        s_d = s_q;
        if (pop) begin
            if (empty) s_d.err = 1'b1;
            else       s_d.cnt = s_q.cnt - CW'(1);
        end else if (push) begin
            if (full) begin
                s_d.err = 1'b1;
            end else begin
                s_d.mem[int'(s_q.cnt)] = push_val;
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign top_val = empty ? '0 : s_q.mem[int'(s_q.cnt) - 1];
    assign err     = s_q.err;

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));
    assert_push_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (s_q.cnt == $past(s_q.cnt) + CW'(1)));
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
    parameter int NSRC        = nic_pkg::NSRC_DEF,
    parameter int RSVD_BIT    = nic_pkg::RSVD_DEF,
    parameter int STACK_DEPTH = nic_pkg::DEPTH_DEF,
    parameter int AW          = nic_pkg::AW_DEF,
    parameter int LW          = $clog2(NSRC + 1),
    parameter int IW          = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_pulse,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_wr,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    input  logic            int_ack,
    input  logic            int_eoi,
    output logic            irq_n,
    output logic [LW-1:0]   svc_level,
    output logic            stk_err
);
    localparam logic [AW-1:0] A_PEND = AW'(nic_pkg::OFS_PEND);
    localparam logic [AW-1:0] A_ENAB = AW'(nic_pkg::OFS_ENAB);
    localparam logic [AW-1:0] A_VECT = AW'(nic_pkg::OFS_VECT);

    typedef struct packed {
        logic [LW-1:0] lvl;
        logic [IW-1:0] vec;
    } core_t;

    core_t c_d, c_q;

    logic [NSRC-1:0] pend, enab;
    logic            any, empty, full, push, pop, take;
    logic [IW-1:0]   win_idx;
    logic [LW-1:0]   win_lvl, top_val;

    nic_src_regs #(.N(NSRC), .RSVD_BIT(RSVD_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
        .pend_we(reg_wr && reg_addr == A_PEND),
        .enab_we(reg_wr && reg_addr == A_ENAB),
        .wdata(reg_wdata), .pend(pend), .enab(enab)
    );

    nic_prio_pick #(.N(NSRC), .LW(LW), .IW(IW)) u_pick (
        .pend(pend), .enab(enab), .cur_lvl(c_q.lvl),
        .any(any), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    nic_lvl_stack #(.DEPTH(STACK_DEPTH), .W(LW)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_val(c_q.lvl), .top_val(top_val),
        .empty(empty), .full(full), .err(stk_err)
    );

    assign pop  = int_eoi;
    assign push = int_ack && !int_eoi && any;
    assign take = push && !full;

    always_comb begin
        c_d = c_q;
        if (pop) begin
            if (!empty) c_d.lvl = top_val;
        end else if (take) begin
            c_d.lvl = win_lvl;
            c_d.vec = win_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        case (reg_addr)
            A_PEND:  reg_rdata = pend;
            A_ENAB:  reg_rdata = enab;
            A_VECT:  reg_rdata = NSRC'(c_q.vec);
            default: reg_rdata = '0;
        endcase
    end

    assign irq_n     = ~any;
    assign svc_level = c_q.lvl;

    assert_level_rises_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (svc_level > $past(svc_level)));
    assert_level_unwinds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_eoi && !empty) |=> (svc_level < $past(svc_level)));
    assert_idle_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_eoi && irq_n) |=> $stable(svc_level));
    assert_full_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> ($stable(svc_level) && stk_err));
endmodule

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] src_pulse = '0;
    logic [5:0] reg_addr = '0;
    logic       reg_wr = 0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       int_ack = 0, int_eoi = 0;
    logic       irq_n, stk_err;
    logic [3:0] svc_level;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nest_irq_ctrl #(.STACK_DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .int_ack(int_ack), .int_eoi(int_eoi), .irq_n(irq_n),
        .svc_level(svc_level), .stk_err(stk_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1; tick(); reg_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic pulse(input logic [7:0] m);
        src_pulse = m; tick(); src_pulse = '0;
    endtask

    task automatic ack();
        int_ack = 1; tick(); int_ack = 0;
    endtask

    task automatic eoi();
        int_eoi = 1; tick(); int_eoi = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; tick(); tick(); rst_n = 1; tick();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        chk("R10 irq_n", irq_n, 1);
        chk("R10 level", svc_level, 0);
        chk("R10 err", stk_err, 0);
        rd(6'h18, v); chk("R10 pending", v, 0);
        rd(6'h1C, v); chk("R10 enable", v, 0);
        rd(6'h20, v); chk("R10 vector", v, 0);
    endtask

    task automatic t_pending();
        logic [7:0] v;
        pulse(8'h21);
        rd(6'h18, v); chk("R1 set", v, 8'h21);
        chk("R4 disabled no irq", irq_n, 1);
        tick(); tick();
        rd(6'h18, v); chk("R1 sticky", v, 8'h21);
        wr(6'h18, 8'h01);
        rd(6'h18, v); chk("R1 w1c", v, 8'h20);
        src_pulse = 8'h20; reg_addr = 6'h18; reg_wdata = 8'h20; reg_wr = 1;
        tick(); reg_wr = 0; src_pulse = '0;
        rd(6'h18, v); chk("R1 set wins", v, 8'h20);
        wr(6'h18, 8'h20);
        rd(6'h18, v); chk("R1 cleared", v, 0);
    endtask

    task automatic t_enable();
        logic [7:0] v;
        wr(6'h1C, 8'hFF);
        rd(6'h1C, v); chk("R2/R3 enable readback", v, 8'hF7);
        pulse(8'h08);
        rd(6'h18, v); chk("R3 pending bit3", v, 0);
        chk("R3 no irq", irq_n, 1);
    endtask

    task automatic t_nest();
        logic [7:0] v;
        pulse(8'h02);
        chk("R4 irq low", irq_n, 0);
        ack();
        chk("R5 level src1", svc_level, 2);
        rd(6'h20, v); chk("R5 vector 1", v, 1);
        chk("R6 same level masked", irq_n, 1);
        pulse(8'h01);
        chk("R6 lower masked", irq_n, 1);
        pulse(8'h10);
        chk("R6 higher raises", irq_n, 0);
        ack();
        chk("R6 level src4", svc_level, 5);
        pulse(8'hC0);
        ack();
        rd(6'h20, v); chk("R5 highest pick", v, 7);
        chk("R5 level 8", svc_level, 8);
        eoi();
        chk("R7 back to 5", svc_level, 5);
        wr(6'h18, 8'h80);
        chk("R4 bit6 still above", irq_n, 0);
        ack();
        rd(6'h20, v); chk("R5 vector 6", v, 6);
        eoi();
        chk("R7 again 5", svc_level, 5);
        eoi();
        chk("R7 back to 2", svc_level, 2);
        eoi();
        chk("R7 idle", svc_level, 0);
        chk("R4 pending at idle", irq_n, 0);
        wr(6'h18, 8'hFF);
        chk("R4 all cleared", irq_n, 1);
        chk("R8 no error", stk_err, 0);
    endtask

    task automatic t_ignore();
        logic [7:0] v;
        ack();
        chk("R9 level kept", svc_level, 0);
        rd(6'h20, v); chk("R9 vector kept", v, 6);
        chk("R9 no error", stk_err, 0);
    endtask

    task automatic t_overflow();
        logic [7:0] v;
        do_reset();
        wr(6'h1C, 8'hF7);
        pulse(8'h01); ack();
        pulse(8'h02); ack();
        pulse(8'h04); ack();
        pulse(8'h10); ack();
        chk("R8 level before full", svc_level, 5);
        pulse(8'h20);
        chk("R8 request seen", irq_n, 0);
        ack();
        chk("R8 overflow err", stk_err, 1);
        chk("R8 level held", svc_level, 5);
        rd(6'h20, v); chk("R8 vector held", v, 4);
    endtask

    task automatic t_underflow();
        do_reset();
        chk("R10 err cleared", stk_err, 0);
        eoi();
        chk("R8 underflow err", stk_err, 1);
        chk("R8 level idle", svc_level, 0);
        tick(); tick();
        chk("R8 err sticky", stk_err, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_pending();
        t_enable();
        t_nest();
        t_ignore();
        t_overflow();
        t_underflow();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule